// File: doc/BRIEF.md
# Xon/Xoff Flow Control Engine

This block performs in-band (software) flow control for a single serial channel. It sits between the receiver and the receive FIFO and watches each received character. A character that matches a programmed stop code makes the local transmitter pause. A character that matches a programmed go code lets it continue. Flow-control characters that match are dropped and never reach the FIFO. Matching works on single characters or on consecutive pairs. Only the data bits that the current word length selects (5 to 8) take part in the comparison.

On the transmit side, the engine watches the receive FIFO fill level. When the level reaches the flow-off threshold, it asks the transmitter to insert the stop code, or the stop pair in pair mode. Once the level falls below the flow-on threshold, it asks for the go code or go pair. There is one request for each crossing, and each character waits for the transmitter to take it between its own characters. A separate special-character mode compares every received character with the fourth code register. A match raises the flow-control flag, and the character is still stored.

Top module: `xonxoff_flow_engine`

## Requirements
- R1: After reset the four code registers (select 0 = go1, 1 = go2, 2 = stop1, 3 = stop2) are zero and tx_suspend, ins_req, fifo_wr and fc_flag are low. A received 0x00 therefore matches in single mode.
- R2: The receive mode is rx_mode 00 = no matching, 01 = single, 1x = pair. In single mode a character equal to stop1 is a stop match, and stop1 wins if stop1 and go1 are equal. A character equal to go1 is a go match. Any other character, go2 included, is stored.
- R3: On a stop match, tx_suspend is high from the cycle after the strobe. fc_flag is also set at that time if fc_irq_en is high.
- R4: On a go match, tx_suspend and fc_flag are both low from the cycle after the strobe.
- R5: A matched flow-control character is never written to the FIFO. Any other character is written unchanged, with fifo_wr high for one cycle in the cycle after its strobe.
- R6: In pair mode, stop1 followed by stop2 is a stop match, and go1 followed by go2 is a go match.
- R7: In pair mode, when a first character that matched is followed by a second character that does not complete the pair, the held first character is written one cycle after the second strobe. The second character is then judged again as a fresh first character one cycle later.
- R8: Comparison uses only bits [4+word_len:0] of the character and the code (word_len 00 = 5 bits to 11 = 8 bits). Higher bits are ignored.
- R9: With special_en high, each character is compared with stop2 and always stored, and rx_mode matching is ignored. A match sets fc_flag if fc_irq_en is high and leaves tx_suspend unchanged.
- R10: With tx_auto_en high and no stop already sent, an rx_count at or above lvl_off raises ins_req carrying stop1 (then stop2 in pair mode). Each character is held until ins_ack.
- R11: After a stop has been sent, an rx_count below lvl_on requests go1 (then go2 in pair mode). Each crossing is requested only once.
- R12: fc_flag_clr clears fc_flag. rx_mode 00 clears tx_suspend on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| code_wr | input | 1 | Write strobe for a code register |
| code_sel | input | 2 | Code register select: 0 go1, 1 go2, 2 stop1, 3 stop2 |
| code_data | input | 8 | Code register write data |
| rx_valid | input | 1 | Received character strobe |
| rx_char | input | 8 | Received character |
| word_len | input | 2 | Data bits: 00 = 5 to 11 = 8 |
| rx_mode | input | 2 | 00 off, 01 single, 1x pair |
| special_en | input | 1 | Special-character detect mode |
| fc_irq_en | input | 1 | Enables setting of fc_flag |
| fc_flag_clr | input | 1 | Clears fc_flag |
| tx_auto_en | input | 1 | Enables automatic stop/go insertion |
| rx_count | input | CNT_W | Receive FIFO fill level |
| lvl_off | input | CNT_W | Flow-off threshold |
| lvl_on | input | CNT_W | Flow-on threshold |
| ins_ack | input | 1 | Transmitter takes the inserted character |
| tx_suspend | output | 1 | Pause the transmitter after its current character |
| ins_req | output | 1 | Insert request |
| ins_char | output | 8 | Character to insert, masked to word length |
| fifo_wr | output | 1 | Write strobe toward the receive FIFO |
| fifo_wr_data | output | 8 | Character to write |
| fc_flag | output | 1 | Flow-control / special-character flag |

## Verification
The bench builds the block with the default CNT_W of 8. This covers fill levels up to 255, so thresholds around a 128-entry FIFO can be crossed in both directions with plain integers. The code registers are programmed to values that differ only in their low bits. This lets one stream show both masking at every word length and the case where a broken pair is replayed as a new first character.

// File: rtl/xfc_pkg.sv
package xfc_pkg;
  localparam int CHAR_W = 8;

  typedef enum logic [1:0] {IS_IDLE = 2'd0, IS_FIRST = 2'd1, IS_SECOND = 2'd2} ins_state_e;

  // Mask of the active data bits: word_len 0..3 selects 5..8 bits.
  function automatic logic [CHAR_W-1:0] len_mask(input logic [1:0] wl);
    return {CHAR_W{1'b1}} >> (2'd3 - wl);
  endfunction

  function automatic logic code_eq(input logic [CHAR_W-1:0] a,
                                   input logic [CHAR_W-1:0] b,
                                   input logic [1:0] wl);
    return ((a ^ b) & len_mask(wl)) == '0;
  endfunction
endpackage

// File: rtl/xfc_code_regs.sv
module xfc_code_regs
  import xfc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [1:0]        sel,
  input  logic [CHAR_W-1:0] data,
  output logic [CHAR_W-1:0] go1,
  output logic [CHAR_W-1:0] go2,
  output logic [CHAR_W-1:0] stop1,
  output logic [CHAR_W-1:0] stop2
);
  localparam int NREG = 4;
  logic [CHAR_W-1:0] regs [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (wr) begin
      regs[sel] <= data;
    end
  end

  assign go1   = regs[0];
  assign go2   = regs[1];
  assign stop1 = regs[2];
  assign stop2 = regs[3];
endmodule

// File: rtl/xfc_rx_matcher.sv
module xfc_rx_matcher
  import xfc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [CHAR_W-1:0] rx_char,
  input  logic [1:0]        word_len,
  input  logic [1:0]        rx_mode,
  input  logic              special_en,
  input  logic [CHAR_W-1:0] go1,
  input  logic [CHAR_W-1:0] go2,
  input  logic [CHAR_W-1:0] stop1,
  input  logic [CHAR_W-1:0] stop2,
  output logic              ev_go,
  output logic              ev_stop,
  output logic              ev_special,
  output logic              ev_release,
  output logic              fifo_wr,
  output logic [CHAR_W-1:0] fifo_wr_data
);
  logic              pend, p_go, p_stop, rep_v;
  logic [CHAR_W-1:0] hold_c, rep_c;

  logic              cur_v;
  logic [CHAR_W-1:0] cur_c, wr_dat;
  logic              wr_now, hold_set, hold_clr;
  logic              first_go, first_stop;

  assign cur_v      = rx_valid | rep_v;
  assign cur_c      = rep_v ? rep_c : rx_char;
  assign first_go   = code_eq(cur_c, go1, word_len);
  assign first_stop = code_eq(cur_c, stop1, word_len);

  always_comb begin
    ev_go = 1'b0; ev_stop = 1'b0; ev_special = 1'b0; ev_release = 1'b0;
    wr_now = 1'b0; wr_dat = cur_c; hold_set = 1'b0; hold_clr = 1'b0;
    if (cur_v) begin
      if (special_en) begin
        wr_now     = 1'b1;
        ev_special = code_eq(cur_c, stop2, word_len);
      end else if (rx_mode == 2'b00) begin
        wr_now = 1'b1;
      end else if (rx_mode == 2'b01) begin
        if (first_stop)    ev_stop = 1'b1;
        else if (first_go) ev_go   = 1'b1;
        else               wr_now  = 1'b1;
      end else if (pend) begin
        hold_clr = 1'b1;
        if (p_go && code_eq(cur_c, go2, word_len))          ev_go   = 1'b1;
        else if (p_stop && code_eq(cur_c, stop2, word_len)) ev_stop = 1'b1;
        else begin
          ev_release = 1'b1;
          wr_now     = 1'b1;
          wr_dat     = hold_c;
        end
      end else if (first_go || first_stop) begin
        hold_set = 1'b1;
      end else begin
        wr_now = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0; p_go <= 1'b0; p_stop <= 1'b0; hold_c <= '0;
      rep_v <= 1'b0; rep_c <= '0;
      fifo_wr <= 1'b0; fifo_wr_data <= '0;
    end else begin
      fifo_wr <= wr_now;
      if (wr_now) fifo_wr_data <= wr_dat;
      rep_v <= ev_release;
      if (ev_release) rep_c <= cur_c;
      if (special_en || !rx_mode[1]) begin
        pend <= 1'b0;
      end else if (hold_set) begin
        pend <= 1'b1; p_go <= first_go; p_stop <= first_stop; hold_c <= cur_c;
      end else if (hold_clr) begin
        pend <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/xfc_tx_inserter.sv
module xfc_tx_inserter
  import xfc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              auto_en,
  input  logic              pair_mode,
  input  logic [1:0]        word_len,
  input  logic [CNT_W-1:0]  rx_count,
  input  logic [CNT_W-1:0]  lvl_off,
  input  logic [CNT_W-1:0]  lvl_on,
  input  logic              ins_ack,
  input  logic [CHAR_W-1:0] go1,
  input  logic [CHAR_W-1:0] go2,
  input  logic [CHAR_W-1:0] stop1,
  input  logic [CHAR_W-1:0] stop2,
  output logic              ins_req,
  output logic [CHAR_W-1:0] ins_char
);
  ins_state_e state;
  logic       kind_stop, remote_off;
  logic [CHAR_W-1:0] raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= IS_IDLE; kind_stop <= 1'b0; remote_off <= 1'b0;
    end else begin
      unique case (state)
        IS_IDLE: begin
          if (!auto_en) begin
            remote_off <= 1'b0;
          end else if (!remote_off && rx_count >= lvl_off) begin
            state <= IS_FIRST; kind_stop <= 1'b1;
          end else if (remote_off && rx_count < lvl_on) begin
            state <= IS_FIRST; kind_stop <= 1'b0;
          end
        end
        IS_FIRST: if (ins_ack) begin
          if (pair_mode) state <= IS_SECOND;
          else begin
            state <= IS_IDLE; remote_off <= kind_stop;
          end
        end
        IS_SECOND: if (ins_ack) begin
          state <= IS_IDLE; remote_off <= kind_stop;
        end
        default: state <= IS_IDLE;
      endcase
    end
  end

  always_comb begin
    if (kind_stop) raw = (state == IS_SECOND) ? stop2 : stop1;
    else           raw = (state == IS_SECOND) ? go2 : go1;
  end

  assign ins_req  = (state != IS_IDLE);
  assign ins_char = raw & len_mask(word_len);
endmodule

// File: rtl/xonxoff_flow_engine.sv
module xonxoff_flow_engine
  import xfc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              code_wr,
  input  logic [1:0]        code_sel,
  input  logic [CHAR_W-1:0] code_data,
  input  logic              rx_valid,
  input  logic [CHAR_W-1:0] rx_char,
  input  logic [1:0]        word_len,
  input  logic [1:0]        rx_mode,
  input  logic              special_en,
  input  logic              fc_irq_en,
  input  logic              fc_flag_clr,
  input  logic              tx_auto_en,
  input  logic [CNT_W-1:0]  rx_count,
  input  logic [CNT_W-1:0]  lvl_off,
  input  logic [CNT_W-1:0]  lvl_on,
  input  logic              ins_ack,
  output logic              tx_suspend,
  output logic              ins_req,
  output logic [CHAR_W-1:0] ins_char,
  output logic              fifo_wr,
  output logic [CHAR_W-1:0] fifo_wr_data,
  output logic              fc_flag
);
  logic [CHAR_W-1:0] go1, go2, stop1, stop2;
  logic ev_go, ev_stop, ev_special, ev_release;

  xfc_code_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr(code_wr), .sel(code_sel), .data(code_data),
    .go1(go1), .go2(go2), .stop1(stop1), .stop2(stop2)
  );

  xfc_rx_matcher u_match (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_char(rx_char),
    .word_len(word_len), .rx_mode(rx_mode), .special_en(special_en),
    .go1(go1), .go2(go2), .stop1(stop1), .stop2(stop2),
    .ev_go(ev_go), .ev_stop(ev_stop), .ev_special(ev_special),
    .ev_release(ev_release), .fifo_wr(fifo_wr), .fifo_wr_data(fifo_wr_data)
  );

  xfc_tx_inserter #(.CNT_W(CNT_W)) u_ins (
    .clk(clk), .rst_n(rst_n), .auto_en(tx_auto_en), .pair_mode(rx_mode[1]),
    .word_len(word_len), .rx_count(rx_count), .lvl_off(lvl_off), .lvl_on(lvl_on),
    .ins_ack(ins_ack), .go1(go1), .go2(go2), .stop1(stop1), .stop2(stop2),
    .ins_req(ins_req), .ins_char(ins_char)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_suspend <= 1'b0;
      fc_flag    <= 1'b0;
    end else begin
      if (ev_stop)               tx_suspend <= 1'b1;
      else if (ev_go)            tx_suspend <= 1'b0;
      else if (rx_mode == 2'b00) tx_suspend <= 1'b0;

      if (ev_go)                                    fc_flag <= 1'b0;
      else if ((ev_stop || ev_special) && fc_irq_en) fc_flag <= 1'b1;
      else if (fc_flag_clr)                         fc_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/xfc_checker.sv
module xfc_checker (
  input logic clk,
  input logic rst_n,
  input logic ev_go,
  input logic ev_stop,
  input logic ev_special,
  input logic ev_release,
  input logic tx_suspend,
  input logic fc_flag,
  input logic fifo_wr,
  input logic ins_req,
  input logic ins_ack
);
  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!tx_suspend && !fc_flag && !fifo_wr && !ins_req));

  a_r3_stop_suspends: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> tx_suspend);

  a_r4_go_resumes: assert property (@(posedge clk) disable iff (!rst_n)
    ev_go |=> (!tx_suspend && !fc_flag));

  a_r5_match_not_stored: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_go || ev_stop) |=> !fifo_wr);

  a_r7_release_writes: assert property (@(posedge clk) disable iff (!rst_n)
    ev_release |=> fifo_wr);

  a_r9_special_stored: assert property (@(posedge clk) disable iff (!rst_n)
    ev_special |=> fifo_wr);

  a_r10_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_req && !ins_ack) |=> ins_req);

  a_r2_events_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_go, ev_stop, ev_special}));
endmodule

bind xonxoff_flow_engine xfc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .ev_go(ev_go), .ev_stop(ev_stop),
  .ev_special(ev_special), .ev_release(ev_release), .tx_suspend(tx_suspend),
  .fc_flag(fc_flag), .fifo_wr(fifo_wr), .ins_req(ins_req), .ins_ack(ins_ack)
);

// File: tb/tb_xonxoff_flow_engine.sv
`timescale 1ns/1ps
module tb_xonxoff_flow_engine;
  localparam int CNT_W = 8;

  logic clk = 0, rst_n = 0;
  logic code_wr = 0; logic [1:0] code_sel = 0; logic [7:0] code_data = 0;
  logic rx_valid = 0; logic [7:0] rx_char = 0;
  logic [1:0] word_len = 2'b11, rx_mode = 2'b00;
  logic special_en = 0, fc_irq_en = 0, fc_flag_clr = 0, tx_auto_en = 0, ins_ack = 0;
  logic [CNT_W-1:0] rx_count = 0, lvl_off = 0, lvl_on = 0;
  logic tx_suspend, ins_req, fifo_wr, fc_flag;
  logic [7:0] ins_char, fifo_wr_data;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] exp_q [$];

  always #4 clk = ~clk;

  xonxoff_flow_engine #(.CNT_W(CNT_W)) dut (.*);

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard on every FIFO write.
  always @(negedge clk) begin
    if (rst_n && fifo_wr) begin
      if (exp_q.size() == 0) check("R5 unexpected write", int'(fifo_wr_data), 999);
      else check("R5 write data", int'(fifo_wr_data), int'(exp_q.pop_front()));
    end
  end

  task automatic expect_wr(input logic [7:0] c);
    exp_q.push_back(c);
  endtask

  task automatic send(input logic [7:0] c, input bit stored);
    @(negedge clk);
    if (stored) expect_wr(c);
    rx_valid = 1; rx_char = c;
    @(negedge clk);
    rx_valid = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic prog(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk); code_wr = 1; code_sel = s; code_data = d;
    @(negedge clk); code_wr = 0;
  endtask

  task automatic pulse_clr;
    @(negedge clk); fc_flag_clr = 1;
    @(negedge clk); fc_flag_clr = 0;
    @(negedge clk);
  endtask

  task automatic ack;
    @(negedge clk); ins_ack = 1;
    @(negedge clk); ins_ack = 0;
  endtask

  task automatic set_count(input int n);
    @(negedge clk); rx_count = CNT_W'(n);
    @(negedge clk);
  endtask

  initial begin
    #(8ns * 150000);
    if (!done) begin
      check("watchdog", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 tx_suspend", tx_suspend, 0);
    check("R1 ins_req", ins_req, 0);
    check("R1 fifo_wr", fifo_wr, 0);
    check("R1 fc_flag", fc_flag, 0);
    // R1 codes are zero: 0x00 matches stop1 in single mode
    rx_mode = 2'b01; fc_irq_en = 1;
    send(8'h00, 0);
    check("R1 zero code stop match", tx_suspend, 1);
    check("R3 flag on stop", fc_flag, 1);
    rx_mode = 2'b00;
    repeat (2) @(negedge clk);
    check("R12 mode off clears suspend", tx_suspend, 0);
    pulse_clr();
    check("R12 flag clear", fc_flag, 0);

    prog(2'd0, 8'h11); prog(2'd1, 8'h12); prog(2'd2, 8'h13); prog(2'd3, 8'h14);

    // Single mode, R2/R3/R4/R5
    rx_mode = 2'b01;
    send(8'h41, 1);
    send(8'h13, 0);
    check("R3 stop suspends", tx_suspend, 1);
    check("R3 flag set", fc_flag, 1);
    send(8'h11, 0);
    check("R4 go resumes", tx_suspend, 0);
    check("R4 flag cleared", fc_flag, 0);
    send(8'h12, 1);
    check("R2 go2 stored in single mode", tx_suspend, 0);

    // R8 word length masking
    word_len = 2'b00;
    send(8'hF3, 0);
    check("R8 5-bit stop", tx_suspend, 1);
    send(8'hD1, 0);
    check("R8 5-bit go", tx_suspend, 0);
    word_len = 2'b11;
    send(8'h93, 1);
    check("R8 8-bit no match", tx_suspend, 0);
    word_len = 2'b10;
    send(8'h93, 0);
    check("R8 7-bit stop", tx_suspend, 1);
    send(8'h11, 0);
    check("R8 7-bit go", tx_suspend, 0);
    word_len = 2'b11;

    // R6/R7 pair mode
    rx_mode = 2'b10;
    send(8'h13, 0);
    check("R6 half pair no action", tx_suspend, 0);
    send(8'h14, 0);
    check("R6 stop pair", tx_suspend, 1);
    send(8'h11, 0);
    send(8'h12, 0);
    check("R6 go pair", tx_suspend, 0);
    send(8'h13, 0);
    expect_wr(8'h13);
    send(8'h55, 1);
    check("R7 broken pair no suspend", tx_suspend, 0);
    send(8'h11, 0);
    expect_wr(8'h11);
    send(8'h13, 0);
    send(8'h14, 0);
    check("R7 replayed char starts pair", tx_suspend, 1);

    // R9 special mode
    rx_mode = 2'b01; special_en = 1;
    pulse_clr();
    send(8'h14, 1);
    check("R9 special flag", fc_flag, 1);
    check("R9 suspend unchanged", tx_suspend, 1);
    pulse_clr();
    send(8'h11, 1);
    check("R9 go ignored in special mode", tx_suspend, 1);
    fc_irq_en = 0;
    send(8'h14, 1);
    check("R9 flag gated by enable", fc_flag, 0);
    special_en = 0; fc_irq_en = 1;
    send(8'h11, 0);
    check("R4 resume after special", tx_suspend, 0);

    // R10/R11 automatic insertion, single mode
    lvl_off = 10; lvl_on = 4; rx_count = 0;
    @(negedge clk); tx_auto_en = 1;
    set_count(9);
    check("R10 below off level", ins_req, 0);
    set_count(10);
    check("R10 stop request", ins_req, 1);
    check("R10 stop char", ins_char, 8'h13);
    repeat (3) @(negedge clk);
    check("R10 held until ack", ins_req, 1);
    ack();
    check("R10 released by ack", ins_req, 0);
    set_count(12);
    check("R11 once per crossing", ins_req, 0);
    set_count(5);
    check("R11 not below on level", ins_req, 0);
    set_count(3);
    check("R11 go request", ins_req, 1);
    check("R11 go char", ins_char, 8'h11);
    ack();
    check("R11 go done", ins_req, 0);

    // pair insertion
    rx_mode = 2'b10;
    set_count(10);
    check("R10 pair first", ins_char, 8'h13);
    ack();
    check("R10 pair second req", ins_req, 1);
    check("R10 pair second", ins_char, 8'h14);
    ack();
    check("R10 pair done", ins_req, 0);
    set_count(0);
    check("R11 pair first", ins_char, 8'h11);
    ack();
    check("R11 pair second", ins_char, 8'h12);
    ack();
    check("R11 pair done", ins_req, 0);

    repeat (4) @(negedge clk);
    check("R5 all expected writes seen", exp_q.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule